// File: doc/BRIEF.md
# UART Receive Queue Interrupt and Line Status

This block is the receive-side status engine of a 16550-class serial port. It keeps a 16-entry receive queue, each entry holding one character and three per-character error flags. It compares the queue occupancy against a selectable threshold to drive a level-style "receive data available" interrupt and a matching interrupt status code. It also builds the eight-bit line status byte that software polls.

The serial deserializer feeds it through a push strobe with data and error flags. The bus interface drains it through a pop strobe and reads the line status byte through a read strobe. The transmit side supplies two empty indications, which appear only in the status byte. When the queue is enabled and every interrupt enable bit is clear, the block runs in polled mode. The interrupt line then stays quiet and the status byte keeps tracking the queue.

Top module: `uart_rx_irq_status`

## Requirements
- R1: The queue holds up to 16 characters and returns them on `rx_data` (head of queue) in arrival order; `rx_data` is valid whenever `line_stat[0]` is 1.
- R2: The threshold is selected by `trig_sel`: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 characters. When `fifo_en` is 0 the threshold is 1 whatever `trig_sel` holds.
- R3: With `int_en[0]` set and the queue occupancy at or above the threshold, `irq` is 1 in the cycle after the push edge that reaches the threshold.
- R4: `irq` returns to 0, and `int_id` returns to 0x1, in the cycle after the pop edge that takes the occupancy below the threshold.
- R5: `int_id` (4 bits) reads 0x4 while the receive-data interrupt is pending and 0x1 when nothing is pending.
- R6: `line_stat[0]` is 1 after a character is stored and stays 1 until the queue is empty.
- R7: A push while the queue is full and no pop occurs in the same cycle discards the character and sets `line_stat[1]` (overrun). A push in the same cycle as a pop from a full queue is stored.
- R8: `line_stat[2]`, `[3]` and `[4]` latch the parity (`push_err[0]`), framing (`push_err[1]`) and break (`push_err[2]`) flags of stored characters. A `stat_rd` strobe clears bits 1 to 4. A flag arriving in the same cycle as the strobe stays set.
- R9: `line_stat[5]` equals `tx_fifo_empty`, and `line_stat[6]` is 1 only when both `tx_fifo_empty` and `tx_shift_empty` are 1.
- R10: `line_stat[7]` is 1 while at least one stored character with any error flag remains in the queue. It is not cleared by `stat_rd`.
- R11: With `fifo_en` set and `int_en[3:0]` all zero, `irq` stays 0 and `int_id` stays 0x1 while the queue and `line_stat` keep updating.
- R12: A pop while the queue is empty has no effect on occupancy or on the data later returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push | input | 1 | Store a received character |
| push_data | input | 8 | Received character |
| push_err | input | 3 | Error flags: [0] parity, [1] framing, [2] break |
| pop | input | 1 | Remove the head character |
| stat_rd | input | 1 | Line status read strobe; clears bits 1 to 4 |
| tx_fifo_empty | input | 1 | Transmit queue is empty |
| tx_shift_empty | input | 1 | Transmit shifter is idle |
| fifo_en | input | 1 | Queue enable |
| int_en | input | 4 | Interrupt enable bits; bit 0 enables receive-data interrupt |
| trig_sel | input | 2 | Threshold select |
| rx_data | output | 8 | Head-of-queue character |
| irq | output | 1 | Interrupt request, level |
| int_id | output | 4 | Interrupt status code |
| line_stat | output | 8 | Line status byte |

## Verification
The hardest state to reach is the full queue meeting a push in the same cycle. It has two outcomes: a lone push drops the character and raises overrun, while a push paired with a pop is kept. The second also has to be told apart from a pop against an empty queue. Directed sequences fill the queue to 16 and then issue both variants, and the random phase biases pushes over pops so the queue often sits at the full boundary. A model in the bench tracks each character and its flags, so the error-present bit is checked as flagged characters leave one by one.

// File: rtl/uart_rxs_pkg.sv
package uart_rxs_pkg;

    // Per-character error flags, bit order matches the status byte bits 2..4
    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } rx_err_t;

    localparam int RX_ERR_W = $bits(rx_err_t);

    // Sticky line error state
    typedef struct packed {
        logic    ovr;
        rx_err_t err;
    } lsr_sticky_t;

endpackage

// File: rtl/uart_rxs_fifo.sv
module uart_rxs_fifo
    import uart_rxs_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  rx_err_t       push_err,
    input  logic          pop,
    output logic [CW-1:0] count,
    output logic [DW-1:0] head_data,
    output logic          err_present,
    output logic          drop_evt,
    output rx_err_t       stored_err
);

    localparam int EW = RX_ERR_W;
    localparam int MW = DW + EW;

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
        logic [CW-1:0] ecnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [MW-1:0] mem_q [DEPTH];

    logic    pop_ok, push_ok;
    rx_err_t head_err;
    logic [AW-1:0] wr_inc, rd_inc;

    assign head_err = rx_err_t'(mem_q[st_q.rd][MW-1:DW]);

    generate
        if ((1 << AW) == DEPTH) begin : g_pow2
            assign wr_inc = st_q.wr + AW'(1);
            assign rd_inc = st_q.rd + AW'(1);
        end else begin : g_wrap
            assign wr_inc = (st_q.wr == AW'(DEPTH - 1)) ? '0 : st_q.wr + AW'(1);
            assign rd_inc = (st_q.rd == AW'(DEPTH - 1)) ? '0 : st_q.rd + AW'(1);
        end
    endgenerate

    always_comb begin
        st_d    = st_q;
        pop_ok  = pop && (st_q.cnt != '0);
        push_ok = push && ((st_q.cnt != CW'(DEPTH)) || pop_ok);
        if (pop_ok) begin
            st_d.rd = rd_inc;
        end
        if (push_ok) begin
            st_d.wr = wr_inc;
        end
        st_d.cnt  = st_q.cnt + CW'(push_ok) - CW'(pop_ok);
        st_d.ecnt = st_q.ecnt + CW'(push_ok && (push_err != '0))
                              - CW'(pop_ok && (head_err != '0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem_q[st_q.wr] <= {push_err, push_data};
        end
    end

    assign count       = st_q.cnt;
    assign head_data   = (st_q.cnt != '0) ? mem_q[st_q.rd][DW-1:0] : '0;
    assign err_present = (st_q.ecnt != '0);
    assign drop_evt    = push && !push_ok;
    assign stored_err  = push_ok ? push_err : '0;

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    assert_push_grows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && count != CW'(DEPTH)) |=> count == $past(count) + CW'(1));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && count == CW'(DEPTH)) |=> count == CW'(DEPTH));

    assert_empty_pop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && count == '0) |=> count == '0);

    assert_err_subset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ecnt <= st_q.cnt);

endmodule

// File: rtl/uart_rxs_lsr.sv
module uart_rxs_lsr
    import uart_rxs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       data_ready,
    input  logic       err_present,
    input  logic       drop_evt,
    input  rx_err_t    stored_err,
    input  logic       stat_rd,
    input  logic       tx_fifo_empty,
    input  logic       tx_shift_empty,
    output logic [7:0] line_stat
);

    lsr_sticky_t sticky_d, sticky_q;
    lsr_sticky_t fresh;

    always_comb begin
        fresh.ovr = drop_evt;
        fresh.err = stored_err;
        sticky_d  = stat_rd ? '0 : sticky_q;
        sticky_d  = sticky_d | fresh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sticky_q <= '0;
        end else begin
            sticky_q <= sticky_d;
        end
    end

    assign line_stat = {err_present,
                        tx_fifo_empty && tx_shift_empty,
                        tx_fifo_empty,
                        sticky_q.err.brk,
                        sticky_q.err.frm,
                        sticky_q.err.par,
                        sticky_q.ovr,
                        data_ready};

    assert_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
        drop_evt |=> line_stat[1]);

    assert_sticky_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !drop_evt && stored_err == '0) |=> line_stat[4:1] == 4'd0);

    assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_rd && line_stat[1]) |=> line_stat[1]);

endmodule

// File: rtl/uart_rxs_irq.sv
module uart_rxs_irq #(
    parameter int CW    = 5,
    parameter int TRIG0 = 1,
    parameter int TRIG1 = 4,
    parameter int TRIG2 = 8,
    parameter int TRIG3 = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    input  logic          fifo_en,
    input  logic [3:0]    int_en,
    input  logic [1:0]    trig_sel,
    output logic          irq,
    output logic [3:0]    int_id
);

    localparam logic [3:0] ID_NONE = 4'h1;
    localparam logic [3:0] ID_RDA  = 4'h4;

    logic [CW-1:0] thr;
    logic          polled, rda;

    always_comb begin
        if (!fifo_en) begin
            thr = CW'(1);
        end else begin
            unique case (trig_sel)
                2'b00:   thr = CW'(TRIG0);
                2'b01:   thr = CW'(TRIG1);
                2'b10:   thr = CW'(TRIG2);
                default: thr = CW'(TRIG3);
            endcase
        end
        polled = fifo_en && (int_en == 4'd0);
        rda    = int_en[0] && !polled && (count >= thr);
        irq    = rda;
        int_id = rda ? ID_RDA : ID_NONE;
    end

    assert_polled_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && int_en == 4'd0) |-> (!irq && int_id == ID_NONE));

    assert_irq_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> int_id == ID_RDA);

    assert_empty_no_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> !irq);

endmodule

// File: rtl/uart_rx_irq_status.sv
module uart_rx_irq_status
    import uart_rxs_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int TRIG0 = 1,
    parameter int TRIG1 = 4,
    parameter int TRIG2 = 8,
    parameter int TRIG3 = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic [2:0]    push_err,
    input  logic          pop,
    input  logic          stat_rd,
    input  logic          tx_fifo_empty,
    input  logic          tx_shift_empty,
    input  logic          fifo_en,
    input  logic [3:0]    int_en,
    input  logic [1:0]    trig_sel,
    output logic [DW-1:0] rx_data,
    output logic          irq,
    output logic [3:0]    int_id,
    output logic [7:0]    line_stat
);

    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] count;
    logic          err_present, drop_evt;
    rx_err_t       stored_err;

    uart_rxs_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_data  (push_data),
        .push_err   (rx_err_t'(push_err)),
        .pop        (pop),
        .count      (count),
        .head_data  (rx_data),
        .err_present(err_present),
        .drop_evt   (drop_evt),
        .stored_err (stored_err)
    );

    uart_rxs_lsr u_lsr (
        .clk           (clk),
        .rst_n         (rst_n),
        .data_ready    (count != '0),
        .err_present   (err_present),
        .drop_evt      (drop_evt),
        .stored_err    (stored_err),
        .stat_rd       (stat_rd),
        .tx_fifo_empty (tx_fifo_empty),
        .tx_shift_empty(tx_shift_empty),
        .line_stat     (line_stat)
    );

    uart_rxs_irq #(.CW(CW), .TRIG0(TRIG0), .TRIG1(TRIG1), .TRIG2(TRIG2), .TRIG3(TRIG3)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .count   (count),
        .fifo_en (fifo_en),
        .int_en  (int_en),
        .trig_sel(trig_sel),
        .irq     (irq),
        .int_id  (int_id)
    );

    assert_temt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        line_stat[6] |-> (tx_shift_empty && line_stat[5]));

    assert_dr_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> line_stat[0]);

endmodule

// File: tb/uart_rx_irq_status_tb.sv
module uart_rx_irq_status_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push = 1'b0;
    logic [7:0] push_data = '0;
    logic [2:0] push_err = '0;
    logic       pop = 1'b0;
    logic       stat_rd = 1'b0;
    logic       tx_fifo_empty = 1'b1;
    logic       tx_shift_empty = 1'b1;
    logic       fifo_en = 1'b1;
    logic [3:0] int_en = 4'd1;
    logic [1:0] trig_sel = 2'b00;
    logic [7:0] rx_data;
    logic       irq;
    logic [3:0] int_id;
    logic [7:0] line_stat;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [10:0] mq[$];
    logic        m_ovr;
    logic [2:0]  m_err;

    always #4 clk = ~clk;

    uart_rx_irq_status u_dut (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .push_err(push_err), .pop(pop), .stat_rd(stat_rd),
        .tx_fifo_empty(tx_fifo_empty), .tx_shift_empty(tx_shift_empty),
        .fifo_en(fifo_en), .int_en(int_en), .trig_sel(trig_sel),
        .rx_data(rx_data), .irq(irq), .int_id(int_id), .line_stat(line_stat)
    );

    function automatic int exp_thr(input logic fe, input logic [1:0] sel);
        if (!fe) return 1;
        case (sel)
            2'b00: return 1;
            2'b01: return 4;
            2'b10: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic logic exp_irq(input logic fe, input logic [3:0] ie,
                                     input logic [1:0] sel, input int cnt);
        if (fe && ie == 4'd0) return 1'b0;
        return ie[0] && (cnt >= exp_thr(fe, sel));
    endfunction

    function automatic int err_entries();
        int n = 0;
        foreach (mq[i]) if (mq[i][10:8] != 3'd0) n++;
        return n;
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        logic ei;
        ei = exp_irq(fifo_en, int_en, trig_sel, mq.size());
        chk(irq == ei, "R3 irq", irq, ei);
        chk(int_id == (ei ? 4'h4 : 4'h1), "R5 int_id", int_id, ei ? 4 : 1);
        chk(line_stat[0] == (mq.size() != 0), "R6 data ready", line_stat[0], mq.size() != 0);
        chk(line_stat[1] == m_ovr, "R7 overrun", line_stat[1], m_ovr);
        chk(line_stat[4:2] == m_err, "R8 error bits", line_stat[4:2], m_err);
        chk(line_stat[6:5] == {tx_fifo_empty && tx_shift_empty, tx_fifo_empty},
            "R9 tx bits", line_stat[6:5], {tx_fifo_empty && tx_shift_empty, tx_fifo_empty});
        chk(line_stat[7] == (err_entries() != 0), "R10 error present",
            line_stat[7], err_entries() != 0);
        if (mq.size() != 0)
            chk(rx_data == mq[0][7:0], "R1 head data", rx_data, mq[0][7:0]);
    endtask

    // one clock: strobes driven after the falling edge, checked 1 ns after the rising edge
    task automatic step(input logic p, input logic [7:0] d, input logic [2:0] e,
                        input logic q, input logic r);
        logic pop_ok, push_ok;
        @(negedge clk);
        push = p; push_data = d; push_err = e; pop = q; stat_rd = r;
        pop_ok  = q && mq.size() > 0;
        push_ok = p && (mq.size() < 16 || pop_ok);
        @(posedge clk);
        #1;
        push = 1'b0; pop = 1'b0; stat_rd = 1'b0;
        if (pop_ok) void'(mq.pop_front());
        if (push_ok) mq.push_back({e, d});
        if (r) begin m_ovr = 1'b0; m_err = 3'd0; end
        if (p && !push_ok) m_ovr = 1'b1;
        if (push_ok) m_err = m_err | e;
        check_all();
    endtask

    task automatic drain();
        while (mq.size() != 0) step(1'b0, 8'h00, 3'd0, 1'b1, 1'b0);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_ovr = 1'b0; m_err = 3'd0;
        repeat (3) @(posedge clk);
        #1;
        // reset state
        chk(line_stat == 8'h60, "R6 reset status", line_stat, 8'h60);
        chk(irq == 1'b0 && int_id == 4'h1, "R5 reset int_id", int_id, 1);
        @(negedge clk); rst_n = 1'b1;

        // R12: pop on empty, then a push must come back intact
        step(1'b0, 8'h00, 3'd0, 1'b1, 1'b0);
        chk(line_stat[0] == 1'b0, "R12 empty pop", line_stat[0], 0);
        step(1'b1, 8'hA5, 3'd0, 1'b0, 1'b0);
        chk(rx_data == 8'hA5, "R12 data after empty pop", rx_data, 8'hA5);
        drain();

        // R2/R3/R4: each threshold, fill to thr-1 then thr, then drop below
        for (int s = 0; s < 4; s++) begin
            int t;
            trig_sel = 2'(s);
            t = exp_thr(1'b1, 2'(s));
            for (int k = 0; k < t - 1; k++) step(1'b1, 8'(k + 16 * s), 3'd0, 1'b0, 1'b0);
            chk(irq == 1'b0, "R2 below threshold", irq, 0);
            step(1'b1, 8'hEE, 3'd0, 1'b0, 1'b0);
            chk(irq == 1'b1 && int_id == 4'h4, "R2 at threshold", irq, 1);
            step(1'b0, 8'h00, 3'd0, 1'b1, 1'b0);
            chk(irq == 1'b0 && int_id == 4'h1, "R4 below again", int_id, 1);
            drain();
        end

        // R2: queue disabled forces threshold 1
        fifo_en = 1'b0; trig_sel = 2'b11;
        step(1'b1, 8'h3C, 3'd0, 1'b0, 1'b0);
        chk(irq == 1'b1, "R2 disabled threshold", irq, 1);
        drain();
        fifo_en = 1'b1;

        // R1/R7: fill to 16, lone push dropped, push with pop kept
        for (int k = 0; k < 16; k++) step(1'b1, 8'(8'h40 + k), 3'd0, 1'b0, 1'b0);
        step(1'b1, 8'hFF, 3'd0, 1'b0, 1'b0);
        chk(line_stat[1] == 1'b1, "R7 overrun set", line_stat[1], 1);
        step(1'b1, 8'h77, 3'd0, 1'b1, 1'b0);
        chk(mq.size() == 16 && rx_data == 8'h41, "R7 push with pop", rx_data, 8'h41);
        step(1'b0, 8'h00, 3'd0, 1'b0, 1'b1);
        chk(line_stat[1] == 1'b0, "R8 read clears", line_stat[1], 0);
        drain();

        // R8/R10: error latching, set wins over clear, error-present follows entries
        step(1'b1, 8'h11, 3'b001, 1'b0, 1'b0);
        step(1'b1, 8'h22, 3'b110, 1'b0, 1'b1);
        chk(line_stat[4:2] == 3'b110, "R8 set wins", line_stat[4:2], 3'b110);
        step(1'b0, 8'h00, 3'd0, 1'b1, 1'b1);
        chk(line_stat[7] == 1'b1 && line_stat[4:2] == 3'd0, "R10 still present", line_stat, 8'h81);
        step(1'b0, 8'h00, 3'd0, 1'b1, 1'b0);
        chk(line_stat[7] == 1'b0, "R10 gone", line_stat[7], 0);

        // R9: transmit indications
        tx_fifo_empty = 1'b1; tx_shift_empty = 1'b0;
        step(1'b0, 8'h00, 3'd0, 1'b0, 1'b0);
        tx_fifo_empty = 1'b0; tx_shift_empty = 1'b1;
        step(1'b0, 8'h00, 3'd0, 1'b0, 1'b0);

        // R11: polled mode
        int_en = 4'd0; trig_sel = 2'b00;
        for (int k = 0; k < 14; k++) step(1'b1, 8'(k), 3'd0, 1'b0, 1'b0);
        chk(irq == 1'b0 && int_id == 4'h1 && line_stat[0], "R11 polled quiet", int_id, 1);
        drain();

        // random phase
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 49) == 0) begin
                @(negedge clk);
                fifo_en = 1'($urandom); int_en = 4'($urandom); trig_sel = 2'($urandom);
                tx_fifo_empty = 1'($urandom); tx_shift_empty = 1'($urandom);
            end
            step($urandom_range(0, 99) < 60, 8'($urandom),
                 ($urandom_range(0, 9) == 0) ? 3'($urandom) : 3'd0,
                 $urandom_range(0, 99) < 45, $urandom_range(0, 19) == 0);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule